// File: doc/BRIEF.md
# SPI Serial EEPROM Protocol Engine

This block is the slave side of a serial EEPROM that holds 512 bytes. An external master drives a select line, a serial clock and a data-in line in SPI mode 0. The block oversamples all three inputs with its own system clock, so every protocol decision is made in the system clock domain. It decodes an 8-bit command, collects an address byte and data, and returns either array contents or a status byte on a serial output that carries its own enable flag.

Bit 8 of the 9-bit address is carried inside the read and write commands, and the following byte supplies the low eight bits. Reads continue for as long as the select line stays low. The address steps forward after each byte and wraps from the top of the array to the bottom. A write stores one byte. It takes effect only when the select line is released at the correct moment, the write-enable latch is set, and the address lies outside the protected region. A committed write starts a programming interval of fixed length, during which the part reports busy.

A status and protection unit keeps the write-enable latch, the two protection-level bits and the busy timer. The protocol engine drives it through one-cycle command strobes.

Top module: `ee_spi_engine`

## Requirements
- R1: Commands are shifted in MSB first on `spi_din`, sampled on rising edges of `spi_clk` after `spi_sel_n` falls. Encodings are 0x06 set write-enable, 0x04 clear write-enable, 0x05 status read and 0x01 status write. Read is 0x03 and write is 0x02, each with address bit 8 placed in bit 3 of the command.
- R2: `spi_dout` changes only after falling edges of `spi_clk` and sends bytes MSB first. While `spi_sel_n` is high, `spi_dout_en` and `spi_dout` are both 0.
- R3: A read sends the command, then the low address byte. The byte at the 9-bit address then appears on `spi_dout`, starting after the next falling edge of `spi_clk`. Data on `spi_din` is ignored during this phase.
- R4: While select stays low, each further 8 clocks return the byte at the next address. Address 0x1FF is followed by 0x000.
- R5: A write (command, address, data) or a status write (command, data) commits only if `spi_sel_n` rises while `spi_clk` is low, after the last data bit and before any further rising clock edge. A release while the clock is high, or an extra rising edge, discards it and leaves the array and status unchanged.
- R6: Writes and status writes need the write-enable latch to be set. A committed write or status write clears the latch. The clear command clears it. A write rejected for protection leaves the latch set.
- R7: The status byte holds busy in bit 0, write-enable in bit 1, the protection level in bits 3:2, and zeros in bits 7:4. While programming is in progress it reads 0xFF. It repeats for as long as select stays low.
- R8: Each commit starts a busy interval of `PROG_CYCLES` system clocks. During that interval data reads return 0xFF, and the set-enable, clear-enable, write and status-write commands have no effect.
- R9: A status write copies data bits 3:2 into the protection level. Level 1 protects 0x180–0x1FF, level 2 protects 0x100–0x1FF and level 3 protects the whole array. A write to a protected address is discarded and starts no busy interval.
- R10: Any other command value is ignored: the output stays disabled and no state changes until select rises.
- R11: After reset the array holds 0xFF in every byte, the latch is clear, the protection level is 0 and the part is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_clk | input | 1 | Serial clock from the master (mode 0) |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_din | input | 1 | Serial data from the master |
| spi_dout | output | 1 | Serial data to the master, 0 when not enabled |
| spi_dout_en | output | 1 | High while `spi_dout` carries valid data |

## Verification
The rise of the select line, which commits a write, can coincide with a rising serial clock edge that follows the last data bit, and the engine must then discard the write. The bench provokes this in two ways. In one, it raises select while the serial clock is still high after the final data bit. In the other, it sends extra clock edges past the data byte before releasing select. Each case is judged through the ports: a later read must return the old byte, and a status read must show the latch still set and the part idle. A control case with correct timing must commit.

// File: rtl/ee_spi_pkg.sv
package ee_spi_pkg;

    localparam int ADDR_W = 9;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_SR_WRITE = 8'h01;
    localparam logic [BYTE_W-1:0] OP_WRITE    = 8'h02;
    localparam logic [BYTE_W-1:0] OP_READ     = 8'h03;
    localparam logic [BYTE_W-1:0] OP_WDISABLE = 8'h04;
    localparam logic [BYTE_W-1:0] OP_SR_READ  = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WENABLE  = 8'h06;
    localparam int               OP_HI_BIT    = 3;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_WHOLD,
        ST_SDATA,
        ST_SHOLD,
        ST_SHIFTOUT,
        ST_IGNORE
    } eng_state_t;

    typedef struct packed {
        logic wren;
        logic wrdi;
        logic wr_commit;
        logic sr_commit;
    } ee_cmd_t;

    // strip the embedded high address bit from a command byte
    function automatic logic [BYTE_W-1:0] op_base(input logic [BYTE_W-1:0] op);
        logic [BYTE_W-1:0] r;
        r = op;
        r[OP_HI_BIT] = 1'b0;
        return r;
    endfunction

    function automatic logic addr_locked(input logic [ADDR_W-1:0] a,
                                         input logic [1:0]        lvl);
        case (lvl)
            2'd0:    return 1'b0;
            2'd1:    return a[ADDR_W-1] & a[ADDR_W-2];
            2'd2:    return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic       busy,
                                                      input logic       wel,
                                                      input logic [1:0] lvl);
        if (busy) return '1;
        return {4'b0000, lvl, wel, 1'b0};
    endfunction

endpackage

// File: rtl/ee_spi_sync.sv
module ee_spi_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [STAGES-1:0][W-1:0] stg;
    logic [W-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= {STAGES{RST_VAL}};
            prev <= RST_VAL;
        end else begin
            stg  <= {stg[STAGES-2:0], din};
            prev <= stg[STAGES-1];
        end
    end

    assign dout = stg[STAGES-1];
    assign rise = dout & ~prev;
    assign fall = ~dout & prev;
endmodule

// File: rtl/ee_array.sv
module ee_array #(
    parameter int           DEPTH  = 512,
    parameter int           W      = 8,
    parameter logic [W-1:0] ERASED = '1,
    localparam int          AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= ERASED;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/ee_status.sv
module ee_status
    import ee_spi_pkg::*;
#(
    parameter int  PROG_CYCLES = 2000,
    localparam int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  ee_cmd_t           cmd,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wel,
    output logic [1:0]        lvl,
    output logic              busy,
    output logic              mem_we
);
    logic [CNT_W-1:0] cnt;
    logic             sr_ok;

    assign busy   = (cnt != '0);
    assign mem_we = cmd.wr_commit & wel & ~busy & ~addr_locked(wr_addr, lvl);
    assign sr_ok  = cmd.sr_commit & wel & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            wel <= 1'b0;
            lvl <= 2'd0;
            cnt <= '0;
        end else begin
            if (busy) cnt <= cnt - 1'b1;
            if (mem_we || sr_ok) begin
                wel <= 1'b0;
                cnt <= CNT_W'(PROG_CYCLES);
            end
            if (sr_ok) lvl <= wr_data[3:2];
            if (!busy && cmd.wren) wel <= 1'b1;
            if (!busy && cmd.wrdi) wel <= 1'b0;
        end
    end
endmodule

// File: rtl/ee_spi_engine.sv
module ee_spi_engine
    import ee_spi_pkg::*;
#(
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_clk,
    input  logic spi_sel_n,
    input  logic spi_din,
    output logic spi_dout,
    output logic spi_dout_en
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [2:0] s_pins, s_rise, s_fall;
    logic       s_sel_n, s_clk, s_din;
    logic       clk_rise, clk_fall, sel_rise;

    ee_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({spi_sel_n, spi_clk, spi_din}),
        .dout(s_pins),
        .rise(s_rise),
        .fall(s_fall)
    );

    assign s_sel_n  = s_pins[2];
    assign s_clk    = s_pins[1];
    assign s_din    = s_pins[0];
    assign sel_rise = s_rise[2];
    assign clk_rise = s_rise[1] & ~s_sel_n;
    assign clk_fall = s_fall[1] & ~s_sel_n;

    eng_state_t        state;
    logic [2:0]        bit_cnt, tx_idx;
    logic [BYTE_W-1:0] rx_sh, tx_sh, wdata, rx_byte, fetch, mem_rdata;
    logic [ADDR_W-1:0] addr;
    logic              hi_bit, is_wr, out_stat;
    logic              wel, busy, mem_we;
    logic [1:0]        lvl;
    logic              byte_done, addr_step;
    ee_cmd_t           cmd;

    assign rx_byte   = {rx_sh[BYTE_W-2:0], s_din};
    assign byte_done = clk_rise && (bit_cnt == 3'd7);
    assign addr_step = clk_fall && (state == ST_SHIFTOUT) && (tx_idx == 3'd7) && !out_stat;

    always_comb begin
        cmd = '0;
        if (byte_done && state == ST_OPCODE) begin
            cmd.wren = (rx_byte == OP_WENABLE);
            cmd.wrdi = (rx_byte == OP_WDISABLE);
        end
        if (sel_rise && !s_clk) begin
            cmd.wr_commit = (state == ST_WHOLD);
            cmd.sr_commit = (state == ST_SHOLD);
        end
    end

    ee_status #(.PROG_CYCLES(PROG_CYCLES)) u_status (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .wr_addr(addr),
        .wr_data(wdata),
        .wel    (wel),
        .lvl    (lvl),
        .busy   (busy),
        .mem_we (mem_we)
    );

    ee_array #(.DEPTH(DEPTH), .W(BYTE_W), .ERASED('1)) u_array (
        .clk  (clk),
        .rst  (rst),
        .we   (mem_we),
        .waddr(addr),
        .wdata(wdata),
        .raddr(addr),
        .rdata(mem_rdata)
    );

    always_comb begin
        if (out_stat)  fetch = status_byte(busy, wel, lvl);
        else if (busy) fetch = '1;
        else           fetch = mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_OPCODE;
            bit_cnt     <= '0;
            tx_idx      <= '0;
            rx_sh       <= '0;
            tx_sh       <= '0;
            wdata       <= '0;
            addr        <= '0;
            hi_bit      <= 1'b0;
            is_wr       <= 1'b0;
            out_stat    <= 1'b0;
            spi_dout    <= 1'b0;
            spi_dout_en <= 1'b0;
        end else if (s_sel_n) begin
            state       <= ST_OPCODE;
            bit_cnt     <= '0;
            tx_idx      <= '0;
            spi_dout    <= 1'b0;
            spi_dout_en <= 1'b0;
        end else begin
            if (clk_rise) begin
                rx_sh   <= rx_byte;
                bit_cnt <= bit_cnt + 3'd1;
                if (state == ST_WHOLD || state == ST_SHOLD) state <= ST_IGNORE;
                if (bit_cnt == 3'd7) begin
                    case (state)
                        ST_OPCODE: begin
                            if (op_base(rx_byte) == OP_READ) begin
                                hi_bit <= rx_byte[OP_HI_BIT];
                                is_wr  <= 1'b0;
                                state  <= ST_ADDR;
                            end else if (op_base(rx_byte) == OP_WRITE && !busy) begin
                                hi_bit <= rx_byte[OP_HI_BIT];
                                is_wr  <= 1'b1;
                                state  <= ST_ADDR;
                            end else if (rx_byte == OP_SR_READ) begin
                                out_stat <= 1'b1;
                                state    <= ST_SHIFTOUT;
                            end else if (rx_byte == OP_SR_WRITE && !busy) begin
                                state <= ST_SDATA;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_ADDR: begin
                            addr     <= {hi_bit, rx_byte};
                            out_stat <= 1'b0;
                            state    <= is_wr ? ST_WDATA : ST_SHIFTOUT;
                        end
                        ST_WDATA: begin
                            wdata <= rx_byte;
                            state <= ST_WHOLD;
                        end
                        ST_SDATA: begin
                            wdata <= rx_byte;
                            state <= ST_SHOLD;
                        end
                        default: ;
                    endcase
                end
            end
            if (clk_fall && state == ST_SHIFTOUT) begin
                spi_dout_en <= 1'b1;
                tx_idx      <= tx_idx + 3'd1;
                if (tx_idx == 3'd0) begin
                    spi_dout <= fetch[BYTE_W-1];
                    tx_sh    <= {fetch[BYTE_W-2:0], 1'b0};
                end else begin
                    spi_dout <= tx_sh[BYTE_W-1];
                    tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
                if (addr_step) addr <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ee_spi_engine_chk.sv
module ee_spi_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       sel_n,
    input logic       dout_en,
    input logic       dout,
    input logic       mem_we,
    input logic       busy,
    input logic       wel,
    input logic       wren_stb,
    input logic       addr_step,
    input logic [8:0] addr
);
    // R2: output idle once deselection has been seen
    a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
        ($past(sel_n) && sel_n) |-> (!dout_en && !dout));

    // R4: top address wraps to zero
    a_r4_addr_wrap: assert property (@(posedge clk) disable iff (rst)
        (addr_step && addr == 9'h1FF) |=> (addr == 9'h000));

    // R4: ordinary step moves up by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (addr_step && addr != 9'h1FF) |=> (addr == $past(addr) + 9'd1));

    // R5: array writes only on the cycle select is seen to rise
    a_r5_commit_on_release: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (sel_n && !$past(sel_n)));

    // R6: a committed write clears the enable latch
    a_r6_wel_drops: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !wel);

    // R6: enable command while idle sets the latch
    a_r6_wren_sets: assert property (@(posedge clk) disable iff (rst)
        (wren_stb && !busy) |=> wel);

    // R8: a committed write starts a programming interval
    a_r8_busy_after_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> busy);
endmodule

bind ee_spi_engine ee_spi_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (s_sel_n),
    .dout_en  (spi_dout_en),
    .dout     (spi_dout),
    .mem_we   (mem_we),
    .busy     (busy),
    .wel      (wel),
    .wren_stb (cmd.wren),
    .addr_step(addr_step),
    .addr     (addr)
);

// File: tb/ee_spi_engine_tb.sv
module ee_spi_engine_tb;
    localparam int HALF = 6;
    localparam int PROG = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_clk = 1'b0;
    logic spi_sel_n = 1'b1;
    logic spi_din = 1'b0;
    logic spi_dout, spi_dout_en;

    int   n_run = 0;
    int   n_fail = 0;
    int   hi_glitch = 0;
    bit   cs_early = 1'b0;
    bit   done = 1'b0;
    logic [7:0] model [512];

    always #4 clk = ~clk;

    ee_spi_engine #(.PROG_CYCLES(PROG)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .spi_clk    (spi_clk),
        .spi_sel_n  (spi_sel_n),
        .spi_din    (spi_din),
        .spi_dout   (spi_dout),
        .spi_dout_en(spi_dout_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic sel();
        spi_sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic desel();
        repeat (2) @(negedge clk);
        spi_sel_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_din = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_dout;
            spi_clk = 1'b1;
            repeat (HALF / 2) @(negedge clk);
            if (spi_dout !== rx[i]) hi_glitch++;
            if (cs_early && i == 0) spi_sel_n = 1'b1;
            repeat (HALF - HALF / 2) @(negedge clk);
            spi_clk = 1'b0;
        end
    endtask

    task automatic cmd_only(input logic [7:0] op);
        logic [7:0] r;
        sel(); xbyte(op, r); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel(); xbyte(8'h05, r); xbyte(8'h00, s); desel();
    endtask

    task automatic sr_wr(input logic [7:0] d);
        logic [7:0] r;
        sel(); xbyte(8'h01, r); xbyte(d, r); desel();
    endtask

    // mode 0 proper release, 1 release with clock high, 2 extra clocks
    task automatic wr(input logic [8:0] a, input logic [7:0] d, input int mode);
        logic [7:0] r;
        sel();
        xbyte({4'b0000, a[8], 3'b010}, r);
        xbyte(a[7:0], r);
        if (mode == 1) cs_early = 1'b1;
        xbyte(d, r);
        cs_early = 1'b0;
        if (mode == 2) xbyte(8'h00, r);
        if (mode == 1) repeat (12) @(negedge clk);
        else desel();
    endtask

    task automatic rd1(input logic [8:0] a, output logic [7:0] v);
        logic [7:0] r;
        sel();
        xbyte({4'b0000, a[8], 3'b011}, r);
        xbyte(a[7:0], r);
        xbyte(8'h5C, v);
        desel();
    endtask

    task automatic read_chk(input logic [8:0] a, input int n, input string req);
        logic [7:0] r;
        logic [7:0] v;
        sel();
        xbyte({4'b0000, a[8], 3'b011}, r);
        xbyte(a[7:0], r);
        for (int k = 0; k < n; k++) begin
            xbyte(8'(k * 13), v);
            chk(req, {7'd0, 9'(a + 9'(k))} << 8 | 16'(v),
                {7'd0, 9'(a + 9'(k))} << 8 | 16'(model[9'(a + 9'(k))]));
        end
        desel();
    endtask

    task automatic wait_ready();
        repeat (PROG + 50) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] s, v, r;
        logic [8:0] wa [5];
        wa[0] = 9'h000; wa[1] = 9'h0FF; wa[2] = 9'h100; wa[3] = 9'h1FF; wa[4] = 9'h080;
        for (int i = 0; i < 512; i++) model[i] = 8'hFF;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R11 / R2: idle outputs and reset status
        chk("R2 dout_en idle after reset", 16'(spi_dout_en), 16'h0);
        chk("R2 dout idle after reset", 16'(spi_dout), 16'h0);
        rdsr(s);
        chk("R11/R7 status after reset", 16'(s), 16'h00);
        read_chk(9'h1FE, 3, "R11 erased array with R4 wrap");

        // R1 R3 R6 R8: enabled writes at both halves of the array
        for (int i = 0; i < 5; i++) begin
            logic [7:0] d;
            d = 8'((int'(wa[i]) * 7 + 3) & 255);
            cmd_only(8'h06);
            rdsr(s);
            chk("R1/R6 enable latch set by 0x06", 16'(s), 16'h02);
            wr(wa[i], d, 0);
            model[wa[i]] = d;
            if (i == 0) begin
                rd1(wa[i], v);
                chk("R8 data read while busy", 16'(v), 16'hFF);
            end else begin
                rdsr(s);
                chk("R7/R8 status while busy", 16'(s), 16'hFF);
                if (i == 1) cmd_only(8'h06);
            end
            wait_ready();
            rdsr(s);
            chk("R6/R8 latch cleared after write, enable ignored while busy", 16'(s), 16'h00);
        end

        // R3 R4: full sequential sweep through the wrap
        read_chk(9'h000, 514, "R3/R4 sequential sweep");

        // R6: write without enable
        wr(9'h010, 8'h77, 0);
        rdsr(s);
        chk("R6 no busy without enable", 16'(s), 16'h00);
        rd1(9'h010, v);
        chk("R6 write without enable discarded", 16'(v), 16'hFF);

        // R6: clear command
        cmd_only(8'h06);
        cmd_only(8'h04);
        rdsr(s);
        chk("R6 latch cleared by 0x04", 16'(s), 16'h00);
        wr(9'h011, 8'h66, 0);
        rd1(9'h011, v);
        chk("R6 write after clear discarded", 16'(v), 16'hFF);

        // R5: release timing
        cmd_only(8'h06);
        wr(9'h020, 8'h12, 1);
        rdsr(s);
        chk("R5 release with clock high: latch kept, idle", 16'(s), 16'h02);
        rd1(9'h020, v);
        chk("R5 release with clock high discarded", 16'(v), 16'hFF);
        wr(9'h021, 8'h34, 2);
        rdsr(s);
        chk("R5 extra clocks: latch kept, idle", 16'(s), 16'h02);
        rd1(9'h021, v);
        chk("R5 extra clocks discarded", 16'(v), 16'hFF);
        wr(9'h022, 8'h99, 0);
        model[9'h022] = 8'h99;
        wait_ready();
        rd1(9'h022, v);
        chk("R5 correct release commits", 16'(v), 16'h99);

        // R9: protection levels
        cmd_only(8'h06);
        sr_wr(8'hF4);
        wait_ready();
        rdsr(s);
        chk("R9/R7 level 1 stored, high bits zero", 16'(s), 16'h04);
        cmd_only(8'h06);
        wr(9'h1C0, 8'h55, 0);
        rdsr(s);
        chk("R9 level 1 rejects 0x1C0, latch kept", 16'(s), 16'h06);
        rd1(9'h1C0, v);
        chk("R9 level 1 protected byte unchanged", 16'(v), 16'(model[9'h1C0]));
        wr(9'h17F, 8'h42, 0);
        model[9'h17F] = 8'h42;
        wait_ready();
        rd1(9'h17F, v);
        chk("R9 level 1 allows 0x17F", 16'(v), 16'h42);

        cmd_only(8'h06);
        sr_wr(8'h08);
        wait_ready();
        cmd_only(8'h06);
        wr(9'h100, 8'h01, 0);
        rdsr(s);
        chk("R9 level 2 rejects 0x100", 16'(s), 16'h0A);
        rd1(9'h100, v);
        chk("R9 level 2 protected byte unchanged", 16'(v), 16'(model[9'h100]));
        wr(9'h0FE, 8'h24, 0);
        model[9'h0FE] = 8'h24;
        wait_ready();
        rd1(9'h0FE, v);
        chk("R9 level 2 allows 0x0FE", 16'(v), 16'h24);

        cmd_only(8'h06);
        sr_wr(8'h0C);
        wait_ready();
        cmd_only(8'h06);
        wr(9'h000, 8'hEE, 0);
        rdsr(s);
        chk("R9 level 3 rejects 0x000", 16'(s), 16'h0E);
        rd1(9'h000, v);
        chk("R9 level 3 protected byte unchanged", 16'(v), 16'(model[9'h000]));
        cmd_only(8'h04);
        sr_wr(8'h00);
        rdsr(s);
        chk("R6/R9 status write without enable ignored", 16'(s), 16'h0C);

        // R10: unknown command
        sel();
        xbyte(8'hA7, r);
        xbyte(8'h05, v);
        chk("R10 unknown command keeps output disabled", 16'({spi_dout_en, v}), 16'h000);
        desel();
        rdsr(s);
        chk("R10 unknown command changes nothing", 16'(s), 16'h0C);

        // R7: status repeats within one selection
        sel();
        xbyte(8'h05, r);
        xbyte(8'h00, s);
        xbyte(8'h00, v);
        desel();
        chk("R7 status repeats", 16'({s, v}), 16'h0C0C);

        chk("R2 output stable during clock high", 16'(hi_glitch), 16'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule